// File: doc/BRIEF.md
# Polled I/O Port Controller

This block is the device side of a polled programmed-I/O port. A host on a simple byte-wide register bus sees four 8-bit registers: a status word, a control word, an input byte and an output byte. To send a byte, the host polls status until the controller is idle. It then writes the output byte, writes the control word with the write-command bit set, and sets the command-ready bit. The controller marks itself busy and reads the command. It takes the byte and offers it on a valid/ready device interface. When the transfer finishes, one step clears busy, command-ready and the error flag at the same time.

If the device does not accept the byte within a timeout that the host programs, the transfer ends with the error flag set. In the other direction, the device can push a byte into the input register at any time. A status bit shows that the byte is waiting, and a host read of the input register consumes it. The duplex and parity mode bits are only stored and passed out to the device side.

The handshake machine has these states:
- ST_IDLE: not busy.
- ST_CLAIM: busy, with the command bit decoded.
- ST_FETCH: the output byte is latched.
- ST_DRIVE: the byte is offered to the device.
- ST_FINISH_OK: a normal completion.
- ST_FINISH_ERR: a timeout completion.

Transitions:
- ST_IDLE→ST_CLAIM when command-ready is set.
- ST_CLAIM→ST_FETCH when the write bit is set.
- ST_CLAIM→ST_FINISH_OK when the write bit is clear.
- ST_FETCH→ST_DRIVE.
- ST_DRIVE→ST_FINISH_OK when the device accepts.
- ST_DRIVE→ST_FINISH_ERR when the timeout expires.
- Both finish states return to ST_IDLE.

Top module: `pio_port_ctrl`

## Requirements
- R1: After reset, the status word (offset 0) and the control word (offset 1) read 0, and `dev_valid` is 0.
- R2: Control (offset 1) holds and reads back these fields: bit 0 write command, bit 1 full-duplex select, bit 2 parity enable, bits 5:3 timeout select, bit 7 command-ready. Bit 6 reads 0. Output byte (offset 3) reads as 0. Duplex and parity appear on `mode_full_duplex` and `mode_parity_en`.
- R3: The status word holds bit 0 busy, bit 1 byte-waiting, bit 2 error and bit 3 a copy of command-ready. When command-ready is 1 and busy is 0, busy reads 1 one cycle later.
- R4: When the write bit is set, `dev_valid` rises three cycles after the command-ready write edge. `dev_data` carries the output byte, and both stay stable until `dev_ready` is sampled high.
- R5: A normal completion clears busy, command-ready and error at the same clock edge. This includes an error left over from an earlier timeout.
- R6: If `dev_ready` is not seen within (sel+1)*TO_STEP cycles of `dev_valid`, where sel is the timeout select, the transfer ends. `dev_valid` falls, and busy and command-ready clear while error becomes 1.
- R7: A command-ready with the write bit clear completes without asserting `dev_valid`.
- R8: Host writes to control or to the output byte while busy is 1 are ignored.
- R9: A `dev_in_valid` pulse loads `dev_in_data` into the input byte (offset 2) and sets byte-waiting. A host read of offset 2 clears byte-waiting.
- R10: If a device byte arrives in the same cycle as a host read of offset 2, the read returns the old byte. Byte-waiting stays 1 and the input byte becomes the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsel | input | 1 | Host access strobe |
| hwr | input | 1 | 1 = write, 0 = read |
| haddr | input | 2 | Register offset |
| hwdata | input | 8 | Host write data |
| hrdata | output | 8 | Host read data (combinational) |
| dev_valid | output | 1 | Output byte offered to device |
| dev_data | output | 8 | Output byte |
| dev_ready | input | 1 | Device accepts the output byte |
| dev_in_valid | input | 1 | Device pushes an input byte |
| dev_in_data | input | 8 | Input byte from device |
| mode_full_duplex | output | 1 | Stored duplex mode bit |
| mode_parity_en | output | 1 | Stored parity enable bit |

## Verification
Two functions can land on the same edge: a host read that consumes the input byte and a device push of a new one. The bench provokes this by driving the offset-2 read and `dev_in_valid` in the same cycle. It expects the old byte on the read data, byte-waiting still set afterwards, and the new byte on the next read. A second overlap is a host write that arrives while the handshake machine is busy. The bench writes control and the output byte during a transfer. It then confirms at the ports that neither changed: it reads control back, and it sends the next transfer without reloading the output byte.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int REG_W = 8;

    localparam logic [1:0] OFS_STATUS = 2'd0;
    localparam logic [1:0] OFS_CTRL   = 2'd1;
    localparam logic [1:0] OFS_DIN    = 2'd2;
    localparam logic [1:0] OFS_DOUT   = 2'd3;

    localparam int CB_WRITE  = 0;
    localparam int CB_DUPLEX = 1;
    localparam int CB_PARITY = 2;
    localparam int CB_TO_LO  = 3;
    localparam int CB_CMDRDY = 7;

    localparam int SB_BUSY   = 0;
    localparam int SB_AVAIL  = 1;
    localparam int SB_ERR    = 2;
    localparam int SB_CMDRDY = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLAIM,
        ST_FETCH,
        ST_DRIVE,
        ST_FINISH_OK,
        ST_FINISH_ERR
    } pio_state_e;

endpackage

// File: rtl/pio_rx_holder.sv
module pio_rx_holder #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic          host_take,
    output logic [DW-1:0] held_byte,
    output logic          avail
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_byte <= '0;
            avail     <= 1'b0;
        end else begin
            if (in_valid) begin
                held_byte <= in_data;
                avail     <= 1'b1;
            end else if (host_take) begin
                avail     <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pio_host_regs.sv
module pio_host_regs
    import pio_pkg::*;
#(
    parameter int DW   = 8,
    parameter int SELW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hsel,
    input  logic            hwr,
    input  logic [1:0]      haddr,
    input  logic [DW-1:0]   hwdata,
    output logic [DW-1:0]   hrdata,
    input  logic            busy,
    input  logic            err_flag,
    input  logic            rx_avail,
    input  logic [DW-1:0]   rx_byte,
    input  logic            clr_cmd,
    output logic            rx_take,
    output logic            cmd_ready,
    output logic            wr_cmd,
    output logic            full_duplex,
    output logic            parity_en,
    output logic [SELW-1:0] to_sel,
    output logic [DW-1:0]   out_byte
);

    localparam int TO_HI = CB_TO_LO + SELW - 1;

    logic wr_ctrl, wr_dout;

    assign wr_ctrl = hsel && hwr && (haddr == OFS_CTRL) && !busy;
    assign wr_dout = hsel && hwr && (haddr == OFS_DOUT) && !busy;
    assign rx_take = hsel && !hwr && (haddr == OFS_DIN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_cmd      <= 1'b0;
            full_duplex <= 1'b0;
            parity_en   <= 1'b0;
            to_sel      <= '0;
            cmd_ready   <= 1'b0;
        end else if (wr_ctrl) begin
            wr_cmd      <= hwdata[CB_WRITE];
            full_duplex <= hwdata[CB_DUPLEX];
            parity_en   <= hwdata[CB_PARITY];
            to_sel      <= hwdata[TO_HI:CB_TO_LO];
            cmd_ready   <= hwdata[CB_CMDRDY];
        end else if (clr_cmd) begin
            cmd_ready   <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_byte <= '0;
        else if (wr_dout) out_byte <= hwdata;
    end

    always_comb begin
        hrdata = '0;
        unique case (haddr)
            OFS_STATUS: begin
                hrdata[SB_BUSY]   = busy;
                hrdata[SB_AVAIL]  = rx_avail;
                hrdata[SB_ERR]    = err_flag;
                hrdata[SB_CMDRDY] = cmd_ready;
            end
            OFS_CTRL: begin
                hrdata[CB_WRITE]          = wr_cmd;
                hrdata[CB_DUPLEX]         = full_duplex;
                hrdata[CB_PARITY]         = parity_en;
                hrdata[TO_HI:CB_TO_LO]    = to_sel;
                hrdata[CB_CMDRDY]         = cmd_ready;
            end
            OFS_DIN:  hrdata = rx_byte;
            OFS_DOUT: hrdata = '0;
            default:  hrdata = '0;
        endcase
    end

endmodule

// File: rtl/pio_handshake_fsm.sv
module pio_handshake_fsm
    import pio_pkg::*;
#(
    parameter int DW      = 8,
    parameter int SELW    = 3,
    parameter int TO_STEP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_ready,
    input  logic            wr_cmd,
    input  logic [DW-1:0]   out_byte,
    input  logic [SELW-1:0] to_sel,
    input  logic            dev_ready,
    output logic            busy,
    output logic            dev_valid,
    output logic [DW-1:0]   dev_data,
    output logic            clr_cmd,
    output logic            err_flag
);

    localparam int MAX_LIMIT = (1 << SELW) * TO_STEP;
    localparam int CNTW      = $clog2(MAX_LIMIT + 1);

    pio_state_e      state, nxt;
    logic [CNTW-1:0] wait_cnt;
    logic [CNTW-1:0] limit;
    logic            cmd_is_write;

    always_comb begin
        limit = CNTW'((int'(to_sel) + 1) * TO_STEP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:       if (cmd_ready) nxt = ST_CLAIM;
            ST_CLAIM:      nxt = cmd_is_write ? ST_FETCH : ST_FINISH_OK;
            ST_FETCH:      nxt = ST_DRIVE;
            ST_DRIVE: begin
                if (dev_ready)                  nxt = ST_FINISH_OK;
                else if (wait_cnt == limit - 1'b1) nxt = ST_FINISH_ERR;
            end
            ST_FINISH_OK:  nxt = ST_IDLE;
            ST_FINISH_ERR: nxt = ST_IDLE;
            default:       nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        busy      = (state != ST_IDLE);
        dev_valid = (state == ST_DRIVE);
        clr_cmd   = (state == ST_FINISH_OK) || (state == ST_FINISH_ERR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_is_write <= 1'b0;
            dev_data     <= '0;
            wait_cnt     <= '0;
            err_flag     <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE:       if (cmd_ready) cmd_is_write <= wr_cmd;
                ST_CLAIM:      wait_cnt <= '0;
                ST_FETCH:      dev_data <= out_byte;
                ST_DRIVE:      wait_cnt <= wait_cnt + 1'b1;
                ST_FINISH_OK:  err_flag <= 1'b0;
                ST_FINISH_ERR: err_flag <= 1'b1;
                default:       ;
            endcase
        end
    end

endmodule

// File: rtl/pio_port_ctrl.sv
module pio_port_ctrl
    import pio_pkg::*;
#(
    parameter int DW      = REG_W,
    parameter int SELW    = 3,
    parameter int TO_STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hsel,
    input  logic          hwr,
    input  logic [1:0]    haddr,
    input  logic [DW-1:0] hwdata,
    output logic [DW-1:0] hrdata,
    output logic          dev_valid,
    output logic [DW-1:0] dev_data,
    input  logic          dev_ready,
    input  logic          dev_in_valid,
    input  logic [DW-1:0] dev_in_data,
    output logic          mode_full_duplex,
    output logic          mode_parity_en
);

    logic            busy_w, err_w, rx_avail_w, rx_take_w, clr_cmd_w;
    logic            cmd_ready_w, wr_cmd_w;
    logic [SELW-1:0] to_sel_w;
    logic [DW-1:0]   out_byte_w, rx_byte_w;

    pio_host_regs #(.DW(DW), .SELW(SELW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .hsel(hsel), .hwr(hwr), .haddr(haddr), .hwdata(hwdata), .hrdata(hrdata),
        .busy(busy_w), .err_flag(err_w), .rx_avail(rx_avail_w), .rx_byte(rx_byte_w),
        .clr_cmd(clr_cmd_w), .rx_take(rx_take_w), .cmd_ready(cmd_ready_w),
        .wr_cmd(wr_cmd_w), .full_duplex(mode_full_duplex), .parity_en(mode_parity_en),
        .to_sel(to_sel_w), .out_byte(out_byte_w)
    );

    pio_handshake_fsm #(.DW(DW), .SELW(SELW), .TO_STEP(TO_STEP)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cmd_ready(cmd_ready_w), .wr_cmd(wr_cmd_w), .out_byte(out_byte_w),
        .to_sel(to_sel_w), .dev_ready(dev_ready),
        .busy(busy_w), .dev_valid(dev_valid), .dev_data(dev_data),
        .clr_cmd(clr_cmd_w), .err_flag(err_w)
    );

    pio_rx_holder #(.DW(DW)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .in_valid(dev_in_valid), .in_data(dev_in_data), .host_take(rx_take_w),
        .held_byte(rx_byte_w), .avail(rx_avail_w)
    );

endmodule

// File: rtl/pio_port_checker.sv
module pio_port_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          cmd_ready,
    input logic          err_flag,
    input logic          rx_avail,
    input logic          dev_valid,
    input logic          dev_ready,
    input logic [DW-1:0] dev_data,
    input logic          dev_in_valid
);

    AST_BUSY_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && !busy) |=> busy); // R3

    AST_VALID_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        dev_valid |-> busy); // R4

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_valid && !dev_ready) |=> (!dev_valid || $stable(dev_data))); // R4

    AST_FINISH_CLEARS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !cmd_ready); // R5

    AST_ERR_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> (!busy && $past(dev_valid, 2) && !$past(dev_ready, 2))); // R6

    AST_RX_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        dev_in_valid |=> rx_avail); // R9

endmodule

bind pio_port_ctrl pio_port_checker #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy_w), .cmd_ready(cmd_ready_w),
    .err_flag(err_w), .rx_avail(rx_avail_w), .dev_valid(dev_valid),
    .dev_ready(dev_ready), .dev_data(dev_data), .dev_in_valid(dev_in_valid)
);

// File: tb/sim_pio_port_ctrl.sv
`timescale 1ns/1ps
module sim_pio_port_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsel = 1'b0, hwr = 1'b0;
    logic [1:0] haddr = 2'd0;
    logic [7:0] hwdata = 8'd0;
    logic [7:0] hrdata;
    logic       dev_valid;
    logic [7:0] dev_data;
    logic       dev_ready = 1'b0;
    logic       dev_in_valid = 1'b0;
    logic [7:0] dev_in_data = 8'd0;
    logic       mode_full_duplex, mode_parity_en;

    int checks = 0;
    int fails  = 0;
    int rdy_delay = 0;
    bit rdy_en = 1'b1;
    int vcnt = 0;
    int valid_cycles = 0;
    logic [7:0] exp_q[$];
    logic [7:0] v;

    always #5 clk = ~clk;

    pio_port_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .hsel(hsel), .hwr(hwr), .haddr(haddr),
        .hwdata(hwdata), .hrdata(hrdata), .dev_valid(dev_valid), .dev_data(dev_data),
        .dev_ready(dev_ready), .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data),
        .mode_full_duplex(mode_full_duplex), .mode_parity_en(mode_parity_en)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic hw(input logic [1:0] a, input logic [7:0] d);
        hsel = 1'b1; hwr = 1'b1; haddr = a; hwdata = d;
        @(posedge clk); @(negedge clk);
        hsel = 1'b0; hwr = 1'b0;
    endtask

    task automatic hr(input logic [1:0] a, output logic [7:0] d);
        hsel = 1'b1; hwr = 1'b0; haddr = a;
        #1 d = hrdata;
        @(posedge clk); @(negedge clk);
        hsel = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 200; i++) begin
            hr(2'd0, s);
            if (s[0] == 1'b0 && s[3] == 1'b0) return;
        end
        check("R5 idle wait", 1, 0);
    endtask

    task automatic send(input logic [7:0] b);
        exp_q.push_back(b);
    endtask

    // device responder, driven away from the active edge
    always @(negedge clk) begin
        if (dev_valid) begin
            valid_cycles++;
            dev_ready = rdy_en && (vcnt >= rdy_delay);
            vcnt++;
        end else begin
            dev_ready = 1'b0;
            vcnt = 0;
        end
    end

    // scoreboard monitor
    always @(posedge clk) begin
        if (rst_n && dev_valid && dev_ready) begin
            if (exp_q.size() == 0) check("R4 unexpected byte", int'(dev_data), -1);
            else check("R4 byte", int'(dev_data), int'(exp_q.pop_front()));
        end
    end

    initial begin
        #200000;
        check("watchdog", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        hr(2'd0, v); check("R1 status", v, 8'h00);
        hr(2'd1, v); check("R1 ctrl", v, 8'h00);
        check("R1 dev_valid", dev_valid, 0);

        // R2 control fields and write-only data-out
        hw(2'd1, 8'h56);
        hr(2'd1, v); check("R2 ctrl readback", v, 8'h16);
        check("R2 duplex pin", mode_full_duplex, 1);
        check("R2 parity pin", mode_parity_en, 1);
        hw(2'd3, 8'hA5);
        hr(2'd3, v); check("R2 dout reads 0", v, 8'h00);

        // R3/R4/R8 write transfer with writes during busy
        hw(2'd1, 8'h01);
        rdy_delay = 1; send(8'hA5);
        hw(2'd1, 8'h81);
        hr(2'd0, v); check("R3 cmd mirror before claim", v, 8'h08);
        hr(2'd0, v); check("R3 busy after cmd", v, 8'h09);
        hw(2'd3, 8'h3C);
        check("R4 valid three cycles after cmd", dev_valid, 1);
        hw(2'd1, 8'h00);
        wait_idle();
        hr(2'd0, v); check("R5 status after done", v, 8'h00);
        hr(2'd1, v); check("R8 ctrl unchanged", v, 8'h01);

        // R8 data-out still old byte; R4 immediate accept
        rdy_delay = 0; send(8'hA5);
        hw(2'd1, 8'h81);
        wait_idle();

        // R4 longer stall
        hw(2'd3, 8'h5A);
        rdy_delay = 3; send(8'h5A);
        hw(2'd1, 8'h81);
        wait_idle();

        // R6 timeout, sel=1 -> 8 cycles
        rdy_en = 1'b0; valid_cycles = 0;
        hw(2'd1, 8'h89);
        wait_idle();
        hr(2'd0, v); check("R6 error status", v, 8'h04);
        check("R6 valid cycle count", valid_cycles, 8);
        check("R6 valid dropped", dev_valid, 0);

        // R5 normal completion clears stale error
        rdy_en = 1'b1; rdy_delay = 0; send(8'h5A);
        hw(2'd1, 8'h81);
        wait_idle();
        hr(2'd0, v); check("R5 error cleared", v, 8'h00);

        // R7 command without write bit
        valid_cycles = 0;
        hw(2'd1, 8'h80);
        wait_idle();
        check("R7 no valid", valid_cycles, 0);
        hr(2'd0, v); check("R7 status", v, 8'h00);

        // R9 receive
        dev_in_valid = 1'b1; dev_in_data = 8'h77;
        @(posedge clk); @(negedge clk);
        dev_in_valid = 1'b0;
        hr(2'd0, v); check("R9 avail set", v, 8'h02);
        hr(2'd2, v); check("R9 data-in", v, 8'h77);
        hr(2'd0, v); check("R9 avail cleared", v, 8'h00);

        // R10 read and arrival in the same cycle
        dev_in_valid = 1'b1; dev_in_data = 8'h11;
        @(posedge clk); @(negedge clk);
        dev_in_data = 8'h22;
        hr(2'd2, v);
        dev_in_valid = 1'b0;
        check("R10 read old byte", v, 8'h11);
        hr(2'd0, v); check("R10 avail kept", v, 8'h02);
        hr(2'd2, v); check("R10 new byte", v, 8'h22);

        check("R4 scoreboard drained", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule